// File: doc/BRIEF.md
# Streaming IPv4 Header Parser

This block sits in the receive clock domain, directly after the MAC layer. It watches a stream of frame bytes. Each byte comes with a qualifier that is high for the whole frame and with the byte's position inside the frame. When the type field of the Ethernet header names IPv4, the block takes the fixed-length IPv4 header as it streams past. It captures the addresses, the protocol number and the total length. It checks the version and header-length nibble and keeps a running 16-bit ones'-complement sum over the header words. No bytes are stored for later processing.

One clock after the last header byte is accepted, the block raises a single-cycle valid pulse. The pulse carries the extracted fields, a checksum-good flag and three separate error flags. The fields keep their values until the next pulse, so slower logic downstream can read them at leisure. If the qualifier drops in the middle of a header, all parsing state is discarded and that frame produces no pulse.

Top module: `ipv4_hdr_parser`

## Requirements
- R1: A header is parsed only when frame byte 12 equals 0x08 and byte 13 equals 0x00. Any other type value produces no pulse and leaves all field outputs at their previous values.
- R2: `hdr_vld` is high for exactly one clock cycle. That cycle follows the clock edge that accepted frame byte 33 (the last of the 20 header bytes at positions 14..33) while `frm_vld` was high.
- R3: When the pulse is raised, the field outputs hold these values: `src_addr` = bytes 26..29, `dst_addr` = bytes 30..33, `proto` = byte 23, `tot_len` = bytes 16..17. In each multi-byte field the first byte is the most significant. The fields change only in a pulse cycle, and any protocol value, including 0x11, 0x06 and 0x01, passes through unchanged.
- R4: The ten 16-bit header words (byte 14+2k is the high byte of word k) are added with end-around carry. A result of 0xFFFF gives `csum_ok`=1 and `csum_err`=0; any other result gives `csum_ok`=0 and `csum_err`=1. Both flags are low outside the pulse cycle, so a failing header is never flagged as good.
- R5: `ver_err` is high in the pulse cycle when the upper nibble of byte 14 is not 4. It is low otherwise.
- R6: `ihl_err` is high in the pulse cycle when the lower nibble of byte 14 is not 5. It is low otherwise.
- R7: If `frm_vld` goes low before byte 33 has been accepted, the partial header is dropped without a pulse. The next complete frame is then parsed correctly.
- R8: While reset is asserted, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_vld | input | 1 | High while the bytes of a frame are being presented |
| rx_byte | input | 8 | Current frame byte |
| byte_idx | input | IDX_W (11) | Position of `rx_byte` in the frame, starting at 0 |
| hdr_vld | output | 1 | One-cycle pulse when an IPv4 header has been fully parsed |
| src_addr | output | 32 | Source address from the last parsed header |
| dst_addr | output | 32 | Destination address from the last parsed header |
| proto | output | 8 | Protocol number from the last parsed header |
| tot_len | output | 16 | Total length from the last parsed header |
| csum_ok | output | 1 | Header checksum correct (pulse cycle only) |
| ver_err | output | 1 | Version nibble is not 4 (pulse cycle only) |
| ihl_err | output | 1 | Header-length nibble is not 5 (pulse cycle only) |
| csum_err | output | 1 | Header checksum wrong (pulse cycle only) |

## Verification
The bench targets several risks:
- Type values that match in only one byte, such as 0x0808 and 0x0900. A parser that decodes a single byte would raise a pulse and overwrite the held addresses.
- A header full of 0xFF bytes, which forces end-around carries on nearly every word. Dropping the carry, or folding it only once at the end, turns that valid header into a checksum failure.
- A deliberately corrupted checksum. A design that let that header through would show `csum_ok` high.
- A frame cut off mid-header and followed by a clean frame. Stale partial sums or a missing clear would either raise a spurious pulse or fail the checksum of the good frame.

// File: rtl/ipv4_parse_pkg.sv
package ipv4_parse_pkg;

    // Live view of the header fields the parser cares about
    typedef struct packed {
        logic [31:0] src;
        logic [31:0] dst;
        logic [7:0]  proto;
        logic [15:0] tot_len;
        logic [3:0]  ver;
        logic [3:0]  ihl;
    } ip_fields_t;

    // 16-bit ones'-complement addition with end-around carry
    function automatic logic [15:0] oc_add(input logic [15:0] a, input logic [15:0] b);
        logic [16:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[15:0] + {15'b0, s[16]};
    endfunction

endpackage

// File: rtl/ipv4_csum_acc.sv
module ipv4_csum_acc
    import ipv4_parse_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        en,
    input  logic        lo_phase,
    input  logic [7:0]  data,
    output logic [15:0] sum_live
);

    typedef struct packed {
        logic [15:0] acc;
        logic [7:0]  hi;
    } csum_st_t;

    csum_st_t st_d, st_q;
    logic [15:0] folded;

    always_comb begin
        folded   = oc_add(st_q.acc, {st_q.hi, data});
        sum_live = (en && lo_phase) ? folded : st_q.acc;
        st_d     = st_q;
        if (clr) begin
            st_d.acc = '0;
            st_d.hi  = '0;
        end else if (en) begin
            if (lo_phase) st_d.acc = folded;
            else          st_d.hi  = data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/ipv4_field_capture.sv
module ipv4_field_capture
    import ipv4_parse_pkg::*;
#(
    parameter int HDR_BYTES = 20,
    parameter int OFF_W     = $clog2(HDR_BYTES)
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [OFF_W-1:0] wr_off,
    input  logic [7:0]       wr_byte,
    output ip_fields_t       live
);

    logic [7:0] hb_d [HDR_BYTES];
    logic [7:0] hb_q [HDR_BYTES];

    // One byte slot per header position; the live view already includes
    // the byte being written this cycle.
    for (genvar k = 0; k < HDR_BYTES; k++) begin : g_slot
        always_comb begin
            hb_d[k] = (wr_en && (wr_off == OFF_W'(k))) ? wr_byte : hb_q[k];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) hb_q[k] <= '0;
            else        hb_q[k] <= hb_d[k];
        end
    end

    always_comb begin
        live.ver     = hb_d[0][7:4];
        live.ihl     = hb_d[0][3:0];
        live.tot_len = {hb_d[2], hb_d[3]};
        live.proto   = hb_d[9];
        live.src     = {hb_d[12], hb_d[13], hb_d[14], hb_d[15]};
        live.dst     = {hb_d[16], hb_d[17], hb_d[18], hb_d[19]};
    end

endmodule

// File: rtl/ipv4_hdr_parser.sv
module ipv4_hdr_parser
    import ipv4_parse_pkg::*;
#(
    parameter int          IDX_W       = 11,
    parameter int          ETH_HDR_LEN = 14,
    parameter logic [15:0] ETYPE_IPV4  = 16'h0800,
    parameter logic [3:0]  IP_VER      = 4'd4,
    parameter logic [3:0]  IP_IHL      = 4'd5
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frm_vld,
    input  logic [7:0]       rx_byte,
    input  logic [IDX_W-1:0] byte_idx,
    output logic             hdr_vld,
    output logic [31:0]      src_addr,
    output logic [31:0]      dst_addr,
    output logic [7:0]       proto,
    output logic [15:0]      tot_len,
    output logic             csum_ok,
    output logic             ver_err,
    output logic             ihl_err,
    output logic             csum_err
);

    localparam int HDR_BYTES = 4 * int'(IP_IHL);
    localparam int OFF_W     = $clog2(HDR_BYTES);
    localparam int ET_HI_IDX = ETH_HDR_LEN - 2;
    localparam int ET_LO_IDX = ETH_HDR_LEN - 1;
    localparam int LAST_IDX  = ETH_HDR_LEN + HDR_BYTES - 1;

    typedef struct packed {
        logic        et_hi_ok;
        logic        in_hdr;
        logic        vld;
        logic        ok;
        logic        cerr;
        logic        verr;
        logic        ierr;
        logic [31:0] src;
        logic [31:0] dst;
        logic [7:0]  proto;
        logic [15:0] len;
    } ctl_st_t;

    ctl_st_t st_d, st_q;

    logic [IDX_W-1:0] rel;
    logic [OFF_W-1:0] off;
    logic             in_win;
    logic             csum_clr;
    logic [15:0]      sum_live;
    ip_fields_t       live;

    always_comb begin
        rel      = byte_idx - IDX_W'(ETH_HDR_LEN);
        off      = rel[OFF_W-1:0];
        in_win   = frm_vld && st_q.in_hdr && (rel < IDX_W'(HDR_BYTES));
        csum_clr = !frm_vld || (byte_idx == IDX_W'(ET_LO_IDX));
    end

    ipv4_csum_acc u_csum (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (csum_clr),
        .en       (in_win),
        .lo_phase (off[0]),
        .data     (rx_byte),
        .sum_live (sum_live)
    );

    ipv4_field_capture #(
        .HDR_BYTES (HDR_BYTES),
        .OFF_W     (OFF_W)
    ) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (in_win),
        .wr_off  (off),
        .wr_byte (rx_byte),
        .live    (live)
    );

    always_comb begin
        st_d      = st_q;
        st_d.vld  = 1'b0;
        st_d.ok   = 1'b0;
        st_d.cerr = 1'b0;
        st_d.verr = 1'b0;
        st_d.ierr = 1'b0;
        if (!frm_vld) begin
            st_d.et_hi_ok = 1'b0;
            st_d.in_hdr   = 1'b0;
        end else if (byte_idx == IDX_W'(ET_HI_IDX)) begin
            st_d.et_hi_ok = (rx_byte == ETYPE_IPV4[15:8]);
            st_d.in_hdr   = 1'b0;
        end else if (byte_idx == IDX_W'(ET_LO_IDX)) begin
            st_d.in_hdr   = st_q.et_hi_ok && (rx_byte == ETYPE_IPV4[7:0]);
        end else if (byte_idx == IDX_W'(LAST_IDX) && st_q.in_hdr) begin
            st_d.in_hdr = 1'b0;
            st_d.vld    = 1'b1;
            st_d.ok     = (sum_live == 16'hFFFF);
            st_d.cerr   = (sum_live != 16'hFFFF);
            st_d.verr   = (live.ver != IP_VER);
            st_d.ierr   = (live.ihl != IP_IHL);
            st_d.src    = live.src;
            st_d.dst    = live.dst;
            st_d.proto  = live.proto;
            st_d.len    = live.tot_len;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hdr_vld  = st_q.vld;
    assign src_addr = st_q.src;
    assign dst_addr = st_q.dst;
    assign proto    = st_q.proto;
    assign tot_len  = st_q.len;
    assign csum_ok  = st_q.ok;
    assign csum_err = st_q.cerr;
    assign ver_err  = st_q.verr;
    assign ihl_err  = st_q.ierr;

    AST_VLD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_vld |=> !hdr_vld) else $error("pulse longer than one cycle"); // R2
    AST_VLD_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_vld |-> ($past(frm_vld) && $past(byte_idx) == IDX_W'(LAST_IDX)))
        else $error("pulse without final header byte"); // R2
    AST_FLAGS_IN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (csum_ok || csum_err || ver_err || ihl_err) |-> hdr_vld)
        else $error("flag outside pulse"); // R4
    AST_CSUM_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_vld |-> (csum_ok != csum_err)) else $error("checksum flags disagree"); // R4
    AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_vld |=> !hdr_vld) else $error("pulse after frame gap"); // R7
    AST_FIELDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !hdr_vld |-> ($stable(src_addr) && $stable(dst_addr) && $stable(proto) && $stable(tot_len)))
        else $error("fields moved outside pulse"); // R3

endmodule

// File: tb/ipv4_hdr_parser_tb_top.sv
module ipv4_hdr_parser_tb_top;

    localparam int FRAME_LEN = 42;

    typedef struct packed {
        logic [15:0] etype;
        logic [7:0]  vi;
        logic [7:0]  proto;
        logic [15:0] len;
        logic [31:0] src;
        logic [31:0] dst;
        logic        bad;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VECS [NVEC] = '{
        '{16'h0800, 8'h45, 8'h11, 16'h0026, 32'hC0A8010A, 32'hC0A80164, 1'b0}, // UDP
        '{16'h0800, 8'h45, 8'h06, 16'h0034, 32'h0A000001, 32'h0A0000FE, 1'b0}, // TCP
        '{16'h0800, 8'h45, 8'h01, 16'h0054, 32'hAC100001, 32'h08080808, 1'b0}, // ICMP
        '{16'h0800, 8'h45, 8'h11, 16'h0030, 32'hC0A80105, 32'hC0A80106, 1'b1}, // bad csum
        '{16'h0800, 8'h65, 8'h11, 16'h0028, 32'h01020304, 32'h05060708, 1'b0}, // ver 6
        '{16'h0800, 8'h46, 8'h06, 16'h0040, 32'h11223344, 32'h55667788, 1'b0}, // ihl 6
        '{16'h0800, 8'h45, 8'hFF, 16'hFFFF, 32'hFFFFFFFF, 32'hFFFFFFFE, 1'b0}, // carries
        '{16'h86DD, 8'h45, 8'h11, 16'h0026, 32'hDEADBEEF, 32'hCAFEF00D, 1'b0}, // other type
        '{16'h0808, 8'h45, 8'h11, 16'h0026, 32'h12345678, 32'h9ABCDEF0, 1'b0}, // hi matches
        '{16'h0900, 8'h45, 8'h11, 16'h0026, 32'h0BADF00D, 32'h0BADCAFE, 1'b0}  // lo matches
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frm_vld = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic [10:0] byte_idx = '0;
    logic        hdr_vld, csum_ok, ver_err, ihl_err, csum_err;
    logic [31:0] src_addr, dst_addr;
    logic [7:0]  proto;
    logic [15:0] tot_len;

    int checks = 0;
    int errors = 0;
    int pulses = 0;
    bit done = 1'b0;
    logic [31:0] c_src, c_dst;
    logic [7:0]  c_proto;
    logic [15:0] c_len;
    logic        c_ok, c_cerr, c_verr, c_ierr;
    logic [7:0]  frame [FRAME_LEN];

    always #10 clk = ~clk;

    ipv4_hdr_parser dut_i (
        .clk(clk), .rst_n(rst_n), .frm_vld(frm_vld), .rx_byte(rx_byte), .byte_idx(byte_idx),
        .hdr_vld(hdr_vld), .src_addr(src_addr), .dst_addr(dst_addr), .proto(proto),
        .tot_len(tot_len), .csum_ok(csum_ok), .ver_err(ver_err), .ihl_err(ihl_err),
        .csum_err(csum_err)
    );

    // Pulse monitor, away from the active edge
    always @(negedge clk) begin
        if (hdr_vld) begin
            pulses++;
            c_src = src_addr; c_dst = dst_addr; c_proto = proto; c_len = tot_len;
            c_ok = csum_ok; c_cerr = csum_err; c_verr = ver_err; c_ierr = ihl_err;
        end
    end

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] fold32(input logic [31:0] s);
        logic [31:0] t;
        t = {16'h0, s[15:0]} + {16'h0, s[31:16]};
        t = {16'h0, t[15:0]} + {16'h0, t[31:16]};
        return t[15:0];
    endfunction

    task automatic build(input vec_t v);
        logic [31:0] s;
        for (int i = 0; i < FRAME_LEN; i++) frame[i] = 8'(i * 7 + 3);
        frame[12] = v.etype[15:8]; frame[13] = v.etype[7:0];
        frame[14] = v.vi;          frame[15] = 8'h00;
        frame[16] = v.len[15:8];   frame[17] = v.len[7:0];
        frame[18] = 8'h1C; frame[19] = 8'h46; frame[20] = 8'h40; frame[21] = 8'h00;
        frame[22] = 8'h40;         frame[23] = v.proto;
        frame[24] = 8'h00;         frame[25] = 8'h00;
        for (int b = 0; b < 4; b++) begin
            frame[26+b] = v.src[31-8*b -: 8];
            frame[30+b] = v.dst[31-8*b -: 8];
        end
        s = '0;
        for (int w = 0; w < 10; w++) s = s + {16'h0, frame[14+2*w], frame[15+2*w]};
        s[15:0] = ~fold32(s);
        if (v.bad) s[15:0] = s[15:0] ^ 16'h0100;
        frame[24] = s[15:8]; frame[25] = s[7:0];
    endtask

    function automatic logic hdr_sum_ok();
        logic [31:0] s;
        s = '0;
        for (int w = 0; w < 10; w++) s = s + {16'h0, frame[14+2*w], frame[15+2*w]};
        return fold32(s) == 16'hFFFF;
    endfunction

    task automatic send(input int cut);
        for (int i = 0; i < FRAME_LEN; i++) begin
            if (cut > 0 && i >= cut) break;
            @(negedge clk);
            frm_vld = 1'b1; byte_idx = 11'(i); rx_byte = frame[i];
        end
        @(negedge clk);
        frm_vld = 1'b0; byte_idx = '0; rx_byte = '0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] h_src, h_dst;
        logic [7:0]  h_proto;
        logic [15:0] h_len;
        int p0;
        repeat (3) @(negedge clk);
        // R8: reset state
        chk("R8", "outputs in reset",
            {31'h0, hdr_vld, csum_ok, csum_err, ver_err, ihl_err, proto, tot_len},
            64'h0);
        chk("R8", "addresses in reset", {src_addr, dst_addr}, 64'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        h_src = '0; h_dst = '0; h_proto = '0; h_len = '0;
        for (int n = 0; n < NVEC; n++) begin
            vec_t v;
            logic want;
            logic good;
            v = VECS[n];
            build(v);
            good = hdr_sum_ok();
            want = (v.etype == 16'h0800);
            p0 = pulses;
            send(0);
            chk("R2", $sformatf("pulse count vec %0d", n), 64'(pulses - p0), want ? 64'd1 : 64'd0);
            if (want) begin
                chk("R3", $sformatf("src vec %0d", n), {32'h0, c_src}, {32'h0, v.src});
                chk("R3", $sformatf("dst vec %0d", n), {32'h0, c_dst}, {32'h0, v.dst});
                chk("R3", $sformatf("proto/len vec %0d", n), {40'h0, c_proto, c_len}, {40'h0, v.proto, v.len});
                chk("R4", $sformatf("csum ok/err vec %0d", n), {62'h0, c_ok, c_cerr}, {62'h0, good, !good});
                chk("R5", $sformatf("ver_err vec %0d", n), {63'h0, c_verr}, {63'h0, v.vi[7:4] != 4'd4});
                chk("R6", $sformatf("ihl_err vec %0d", n), {63'h0, c_ierr}, {63'h0, v.vi[3:0] != 4'd5});
                chk("R4", $sformatf("flags low after pulse vec %0d", n),
                    {60'h0, csum_ok, csum_err, ver_err, ihl_err}, 64'h0);
                h_src = v.src; h_dst = v.dst; h_proto = v.proto; h_len = v.len;
            end else begin
                // R1: fields hold after a non-IPv4 frame
                chk("R1", $sformatf("fields held vec %0d", n), {src_addr, dst_addr}, {h_src, h_dst});
                chk("R1", $sformatf("proto/len held vec %0d", n), {40'h0, proto, tot_len}, {40'h0, h_proto, h_len});
            end
        end

        // R7: cut mid-header, then a clean frame
        build(VECS[1]);
        p0 = pulses;
        send(24);
        chk("R7", "no pulse for cut frame", 64'(pulses - p0), 64'd0);
        chk("R7", "fields held after cut", {src_addr, dst_addr}, {h_src, h_dst});
        build(VECS[2]);
        p0 = pulses;
        send(33);
        chk("R7", "no pulse when cut before last byte", 64'(pulses - p0), 64'd0);
        build(VECS[0]);
        p0 = pulses;
        send(0);
        chk("R7", "pulse after recovery", 64'(pulses - p0), 64'd1);
        chk("R7", "fields after recovery", {c_src, c_dst}, {VECS[0].src, VECS[0].dst});
        chk("R7", "csum good after recovery", {62'h0, c_ok, c_cerr}, 64'h2);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule